// File: doc/BRIEF.md
# Four-Slot Transfer Descriptor Queue

This block is the per-channel command queue that sits between software and a transfer engine. Software builds each transfer descriptor by writing four 32-bit words in a row to one push address. The words are a 64-bit buffer address (low word first), a byte count and a flags word. The block gathers the words into a holding stage. When the last word arrives, it commits the whole descriptor to one of four slots in a single cycle.

The transfer engine sees the oldest committed descriptor on the pop side as one wide value, together with a valid flag. It takes that descriptor by raising a pop request. Software watches a status word that packs both 2-bit slot indices, an empty bit, a full bit and a sticky error bit. The error bit is raised when a descriptor is lost to a full queue and is cleared by writing a 1 to it. A control bit holds the queue in a cleared state for as long as it stays set.

Top module: `desc_ring_queue`

## Requirements
- R1: While rst_n is low at a clock edge, the queue becomes empty with both slot indices 0, the word index 0, the error bit 0 and the control bit 0, so the status word reads 0x100 and desc_valid is 0.
- R2: A read at reg_addr 1 returns the status word: write slot in bits 1:0, read slot in bits 5:4, empty in bit 8, full in bit 9, error in bit 10, all other bits 0.
- R3: Empty is set exactly when no descriptor is held, and full exactly when four are held. The two are never set together, even though the slot indices are equal in both states.
- R4: Four writes to reg_addr 0 are taken in this order: address bits 31:0, address bits 63:32, byte length, flags. The descriptor at the read slot is shown on desc_addr, desc_len and desc_flags.
- R5: desc_notify equals bit 16 of the flags word of the descriptor at the read slot.
- R6: The write slot moves on by one only when the fourth word of a descriptor is written and the queue is not full. The first three words change no status bit.
- R7: A fourth word written while the queue is full throws the descriptor away and sets the error bit. Both slot indices stay as they were, and the next word written to reg_addr 0 is again taken as an address low word.
- R8: A pop request while desc_valid is 1 moves the read slot on by one. A pop request while the queue is empty has no effect.
- R9: Writing a 1 to bit 0 at reg_addr 2 sets both slot indices and the word index to 0 in that same cycle. The queue stays cleared, ignoring pushes and pops, until bit 0 is written back to 0. The error bit is not changed by this.
- R10: Writing to reg_addr 1 with bit 10 set clears the error bit. Writing there with bit 10 clear leaves the error bit unchanged.
- R11: When a fourth word and an accepted pop fall in the same cycle, both take effect. Whether the push overflows is decided on the occupancy before the pop.
- R12: A read at reg_addr 2 returns the control bit in bit 0. A read at reg_addr 0 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 push, 1 status, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| pop_req | input | 1 | Consumer takes the descriptor at the read slot |
| desc_valid | output | 1 | A descriptor is held at the read slot |
| desc_addr | output | 64 | Buffer address of the head descriptor |
| desc_len | output | 32 | Byte count of the head descriptor |
| desc_flags | output | 32 | Flags word of the head descriptor |
| desc_notify | output | 1 | Head descriptor asks for a completion notice |

## Verification
Completing a push and accepting a pop can happen in the same cycle, and the case that matters most is when the queue is full. The bench sets this up by filling all four slots and then driving the fourth word of a new descriptor in the same cycle as pop_req. The expected result is a set error bit, a write slot that has not moved and a read slot one place further on. A second test starts from three held descriptors and expects both indices to move while occupancy stays the same.

// File: rtl/desc_ring_pkg.sv
// Package: shared constants and types for the descriptor queue.
// Assumes the queue depth is a power of two, with each slot index in a
// 2-bit status field.
package desc_ring_pkg;
    localparam int WORD_W     = 32;
    localparam int SLOT_BITS  = 2;
    localparam int DEPTH      = 1 << SLOT_BITS;
    localparam int WORDS_PER  = 4;
    localparam int WIDX_BITS  = $clog2(WORDS_PER);

    // Status word bit positions
    localparam int ST_WR_LSB  = 0;
    localparam int ST_RD_LSB  = 4;
    localparam int ST_EMPTY   = 8;
    localparam int ST_FULL    = 9;
    localparam int ST_ERR     = 10;

    localparam int CTL_CLEAR  = 0;
    localparam int FLAG_NOTIFY = 16;

    typedef enum logic [1:0] {
        RA_PUSH   = 2'd0,
        RA_STATUS = 2'd1,
        RA_CTRL   = 2'd2,
        RA_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2*WORD_W-1:0] addr;
        logic [WORD_W-1:0]   len;
        logic [WORD_W-1:0]   flags;
    } desc_t;
endpackage

// File: rtl/desc_word_gather.sv
// Module: collects the four sequential push words into one descriptor.
// Assumes the words arrive in the order addr low, addr high, length,
// flags. The index wraps to 0 after the flags word or on a clear.
module desc_word_gather
    import desc_ring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 word_we,
    input  logic [WORD_W-1:0]    word_data,
    output logic [WIDX_BITS-1:0] word_idx,
    output logic                 last_word,
    output desc_t                gathered
);
    localparam logic [WIDX_BITS-1:0] LAST_IDX = WIDX_BITS'(WORDS_PER - 1);

    logic [WORD_W-1:0] addr_lo_q, addr_hi_q, len_q;

    // Word position counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            word_idx <= '0;
        else if (word_we)
            word_idx <= (word_idx == LAST_IDX) ? '0 : word_idx + 1'b1;
    end

    // Holding registers for the first three words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            len_q     <= '0;
        end else if (word_we && !clr) begin
            case (word_idx)
                2'd0:    addr_lo_q <= word_data;
                2'd1:    addr_hi_q <= word_data;
                2'd2:    len_q     <= word_data;
                default: ;
            endcase
        end
    end

    // Complete descriptor, with the flags word taken live
    always_comb begin
        last_word      = word_we && !clr && (word_idx == LAST_IDX);
        gathered.addr  = {addr_hi_q, addr_lo_q};
        gathered.len   = len_q;
        gathered.flags = word_data;
    end
endmodule

// File: rtl/desc_slot_ptrs.sv
// Module: write and read slot indices with an occupancy count.
// Assumes push_en and pop_en are already qualified against full and
// empty by the caller.
module desc_slot_ptrs #(
    parameter int SLOTW = desc_ring_pkg::SLOT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push_en,
    input  logic             pop_en,
    output logic [SLOTW-1:0] wr_slot,
    output logic [SLOTW-1:0] rd_slot,
    output logic             full,
    output logic             empty
);
    localparam int            CNTW  = SLOTW + 1;
    localparam logic [CNTW-1:0] SLOTS = CNTW'(1 << SLOTW);

    logic [CNTW-1:0] count_q;

    // Slot indices
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_slot <= '0;
            rd_slot <= '0;
        end else begin
            if (push_en) wr_slot <= wr_slot + 1'b1;
            if (pop_en)  rd_slot <= rd_slot + 1'b1;
        end
    end

    // Occupancy, which tells full from empty when the indices match
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count_q <= '0;
        else if (push_en && !pop_en)
            count_q <= count_q + 1'b1;
        else if (pop_en && !push_en)
            count_q <= count_q - 1'b1;
    end

    // Flags from occupancy
    always_comb begin
        full  = (count_q == SLOTS);
        empty = (count_q == '0);
    end
endmodule

// File: rtl/desc_slot_store.sv
// Module: storage for the descriptor slots, one register set per slot.
// Assumes a single write port and one combinational read port.
module desc_slot_store
    import desc_ring_pkg::*;
#(
    parameter int SLOTW = SLOT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SLOTW-1:0] waddr,
    input  desc_t            wdesc,
    input  logic [SLOTW-1:0] raddr,
    output desc_t            rdesc
);
    localparam int NSLOT = 1 << SLOTW;

    desc_t slot_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Load one slot when it is the write target
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (we && (waddr == SLOTW'(g)))
                slot_q[g] <= wdesc;
        end
    end

    // Head read
    always_comb rdesc = slot_q[raddr];
endmodule

// File: rtl/desc_ring_queue.sv
// Module: four-slot transfer descriptor queue with serial word push,
// status and control registers, and a pop port for a transfer engine.
// Assumes one register access per cycle. The control clear bit
// overrides pushes and pops.
module desc_ring_queue
    import desc_ring_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          pop_req,
    output logic          desc_valid,
    output logic [63:0]   desc_addr,
    output logic [31:0]   desc_len,
    output logic [31:0]   desc_flags,
    output logic          desc_notify
);
    reg_sel_e              sel;
    logic                  push_wr, status_wr, ctrl_wr;
    logic                  ctrl_q, ring_clr;
    logic                  err_q, overflow;
    logic [WIDX_BITS-1:0]  word_idx;
    logic                  last_word, push_en, pop_en;
    logic [SLOT_BITS-1:0]  wr_slot, rd_slot;
    logic                  full, empty;
    desc_t                 gathered, head;

    // Register strobe decode
    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        push_wr   = reg_wr && (sel == RA_PUSH);
        status_wr = reg_wr && (sel == RA_STATUS);
        ctrl_wr   = reg_wr && (sel == RA_CTRL);
        ring_clr  = ctrl_q || (ctrl_wr && reg_wdata[CTL_CLEAR]);
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 1'b0;
        else if (ctrl_wr)
            ctrl_q <= reg_wdata[CTL_CLEAR];
    end

    desc_word_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ring_clr),
        .word_we   (push_wr),
        .word_data (reg_wdata),
        .word_idx  (word_idx),
        .last_word (last_word),
        .gathered  (gathered)
    );

    // Accept decisions, with overflow judged on the pre-pop occupancy
    always_comb begin
        push_en  = last_word && !full;
        overflow = last_word && full;
        pop_en   = pop_req && !empty && !ring_clr;
    end

    desc_slot_ptrs #(.SLOTW(SLOT_BITS)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ring_clr),
        .push_en (push_en),
        .pop_en  (pop_en),
        .wr_slot (wr_slot),
        .rd_slot (rd_slot),
        .full    (full),
        .empty   (empty)
    );

    desc_slot_store #(.SLOTW(SLOT_BITS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push_en),
        .waddr (wr_slot),
        .wdesc (gathered),
        .raddr (rd_slot),
        .rdesc (head)
    );

    // Sticky error, set on overflow and cleared by a write of 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (overflow)
            err_q <= 1'b1;
        else if (status_wr && reg_wdata[ST_ERR])
            err_q <= 1'b0;
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (sel)
            RA_STATUS: begin
                reg_rdata[ST_WR_LSB +: SLOT_BITS] = wr_slot;
                reg_rdata[ST_RD_LSB +: SLOT_BITS] = rd_slot;
                reg_rdata[ST_EMPTY]               = empty;
                reg_rdata[ST_FULL]                = full;
                reg_rdata[ST_ERR]                 = err_q;
            end
            RA_CTRL: reg_rdata[CTL_CLEAR] = ctrl_q;
            default: reg_rdata = '0;
        endcase
    end

    // Pop side outputs
    always_comb begin
        desc_valid  = !empty;
        desc_addr   = head.addr;
        desc_len    = head.len;
        desc_flags  = head.flags;
        desc_notify = head.flags[FLAG_NOTIFY];
    end
endmodule

// File: rtl/desc_ring_checker.sv
// Module: property checker for the descriptor queue, bound to its top.
// Assumes it sees the top's internal slot indices, flags and word index.
module desc_ring_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic       pop_req,
    input logic       desc_valid,
    input logic [1:0] wr_slot,
    input logic [1:0] rd_slot,
    input logic [1:0] word_idx,
    input logic       full,
    input logic       empty,
    input logic       err_q,
    input logic       ring_clr
);
    logic fourth_wr;
    always_comb fourth_wr = reg_wr && (reg_addr == 2'd0) && (word_idx == 2'd3) && !ring_clr;

    assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_push_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fourth_wr && !full) |=> (wr_slot == 2'($past(wr_slot) + 2'd1)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fourth_wr && full) |=> (err_q && $stable(wr_slot) && (word_idx == 2'd0)));

    assert_pop_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && desc_valid && !ring_clr) |=> (rd_slot == 2'($past(rd_slot) + 2'd1)));

    assert_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !desc_valid && !fourth_wr) |=> $stable(rd_slot));

    assert_ring_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ring_clr |=> (wr_slot == 2'd0 && rd_slot == 2'd0 && word_idx == 2'd0 && empty));

    assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[10]) |=> !err_q);
endmodule

bind desc_ring_queue desc_ring_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .pop_req    (pop_req),
    .desc_valid (desc_valid),
    .wr_slot    (wr_slot),
    .rd_slot    (rd_slot),
    .word_idx   (word_idx),
    .full       (full),
    .empty      (empty),
    .err_q      (err_q),
    .ring_clr   (ring_clr)
);

// File: tb/test_desc_ring_queue.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module test_desc_ring_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pop_req = 1'b0;
    logic        desc_valid;
    logic [63:0] desc_addr;
    logic [31:0] desc_len;
    logic [31:0] desc_flags;
    logic        desc_notify;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    desc_ring_queue i_desc_ring_queue (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop_req(pop_req),
        .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_len(desc_len),
        .desc_flags(desc_flags), .desc_notify(desc_notify)
    );

    // Vector fields: kind(2) pop(1) data(32) expected status(32)
    // kind 0 push word, 1 status write, 2 control write, 3 idle
    localparam int NVEC = 13;
    localparam logic [66:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 32'h0000_1000, 32'h100},  // R6 partial
        {2'd0, 1'b0, 32'h0000_0000, 32'h100},
        {2'd0, 1'b0, 32'h0000_0040, 32'h100},
        {2'd0, 1'b0, 32'h0001_0000, 32'h001},  // R4 commit
        {2'd0, 1'b0, 32'h0000_2000, 32'h001},
        {2'd0, 1'b0, 32'h0000_0001, 32'h001},
        {2'd0, 1'b0, 32'h0000_0080, 32'h001},
        {2'd0, 1'b0, 32'h0000_0000, 32'h002},
        {2'd3, 1'b1, 32'h0000_0000, 32'h012},  // R8 pop
        {2'd3, 1'b1, 32'h0000_0000, 32'h122},  // R3 empty again
        {2'd1, 1'b0, 32'h0000_0400, 32'h122},  // R10 no error present
        {2'd2, 1'b0, 32'h0000_0001, 32'h100},  // R9 clear
        {2'd2, 1'b0, 32'h0000_0000, 32'h100}
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // One clock with the given access, then return with status selected
    task automatic cyc(input logic [1:0] kind, input logic [31:0] data, input logic pop);
        reg_wr    = (kind != 2'd3);
        reg_addr  = (kind == 2'd0) ? 2'd0 : (kind == 2'd1) ? 2'd1 : 2'd2;
        reg_wdata = data;
        pop_req   = pop;
        @(posedge clk);
        @(negedge clk);
        reg_wr   = 1'b0;
        pop_req  = 1'b0;
        reg_addr = 2'd1;
        #1;
    endtask

    task automatic push4(input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] len, input logic [31:0] fl);
        cyc(2'd0, lo, 1'b0);
        cyc(2'd0, hi, 1'b0);
        cyc(2'd0, len, 1'b0);
        cyc(2'd0, fl, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 status after reset", reg_rdata, 32'h100);
        check("R1 valid after reset", desc_valid, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i][66:65], VEC[i][63:32], VEC[i][64]);
            check($sformatf("R2 R6 R8 vector %0d", i), reg_rdata, VEC[i][31:0]);
        end

        // R9: partial words are dropped by a clear
        cyc(2'd0, 32'hAAAA, 1'b0);
        cyc(2'd0, 32'hBBBB, 1'b0);
        cyc(2'd2, 32'h1, 1'b0);
        cyc(2'd0, 32'hCCCC, 1'b0);
        check("R9 push ignored during clear", reg_rdata, 32'h100);
        reg_addr = 2'd2; #1;
        check("R12 control readback", reg_rdata, 32'h1);
        reg_addr = 2'd0; #1;
        check("R12 push address reads zero", reg_rdata, 32'h0);
        cyc(2'd2, 32'h0, 1'b0);
        push4(32'h3000, 32'h0, 32'h10, 32'h0001_0000);
        check("R9 word index restarted", reg_rdata, 32'h001);
        check("R4 address after clear", desc_addr, 64'h3000);
        check("R4 length", desc_len, 32'h10);
        check("R5 notify set", desc_notify, 1'b1);

        // R3: fill to four
        push4(32'h4000, 32'h0, 32'h20, 32'h0);
        push4(32'h5000, 32'h7, 32'h30, 32'h0001_0000);
        push4(32'h6000, 32'h0, 32'h40, 32'h0);
        check("R3 full with equal indices", reg_rdata, 32'h200);

        // R7: overflow
        cyc(2'd0, 32'h9000, 1'b0);
        cyc(2'd0, 32'h0, 1'b0);
        cyc(2'd0, 32'h50, 1'b0);
        check("R6 three words change nothing", reg_rdata, 32'h200);
        cyc(2'd0, 32'h0, 1'b0);
        check("R7 overflow sets error", reg_rdata, 32'h600);
        check("R7 head unchanged", desc_addr, 64'h3000);

        // R10
        cyc(2'd1, 32'h0, 1'b0);
        check("R10 write of 0 keeps error", reg_rdata, 32'h600);
        cyc(2'd1, 32'h400, 1'b0);
        check("R10 write of 1 clears error", reg_rdata, 32'h200);

        // R11: fourth word and pop together while full
        cyc(2'd0, 32'hA000, 1'b0);
        cyc(2'd0, 32'h0, 1'b0);
        cyc(2'd0, 32'h60, 1'b0);
        cyc(2'd0, 32'h0, 1'b1);
        check("R11 full push with pop overflows", reg_rdata, 32'h410);
        check("R5 notify clear", desc_notify, 1'b0);
        cyc(2'd1, 32'h400, 1'b0);
        check("R10 clear after overflow", reg_rdata, 32'h010);

        // R11: push and pop together at three held
        cyc(2'd0, 32'hB000, 1'b0);
        cyc(2'd0, 32'h0, 1'b0);
        cyc(2'd0, 32'h70, 1'b0);
        cyc(2'd0, 32'h0, 1'b1);
        check("R11 both indices move", reg_rdata, 32'h021);
        check("R4 high address word", desc_addr, 64'h0000_0007_0000_5000);
        check("R5 notify on third", desc_notify, 1'b1);

        // R8: drain and pop on empty
        cyc(2'd3, 32'h0, 1'b1);
        check("R4 slot3 content", desc_addr, 64'h6000);
        cyc(2'd3, 32'h0, 1'b1);
        check("R4 wrapped slot content", desc_addr, 64'hB000);
        cyc(2'd3, 32'h0, 1'b1);
        check("R3 empty after drain", reg_rdata, 32'h111);
        cyc(2'd3, 32'h0, 1'b1);
        check("R8 pop on empty ignored", reg_rdata, 32'h111);
        check("R8 valid low when empty", desc_valid, 1'b0);

        // R1: reset again from a non-empty state
        push4(32'hC000, 32'h0, 32'h80, 32'h0);
        rst_n = 1'b0;
        cyc(2'd3, 32'h0, 1'b0);
        rst_n = 1'b1;
        #1;
        check("R1 reset clears queue", reg_rdata, 32'h100);

        finish_run();
    end
endmodule